// File: doc/BRIEF.md
# Dual-Loop Phase-Frequency Detector with Lock Monitor

This block serves two frequency-synthesis loops. For each loop it compares a one-cycle reference pulse, coming from the reference divider, with a one-cycle feedback pulse, coming from the feedback divider. It uses a three-state phase-frequency detector and turns the result into digital pump-up and pump-down controls for an external charge pump. Alongside these it drives an enable that, when low, puts the pump in its high-impedance state, and a flag that selects the drive strength.

A phase-sense bit sets the direction of correction to match the slope of the oscillator. A forced high-impedance bit and a power-down bit can each silence the pump outputs. Power-down also stops the comparator.

Each loop has its own lock detector. It measures every comparison in clock cycles and declares lock after eight consecutive narrow comparisons. A single monitor pin carries one of the following, chosen by configuration bits: the lock signal of either loop, the combined lock of both loops, a divider pulse stream, or a fixed level. The monitor pin is meant for a lock indicator or for bench test.

Top module: `pfd_lock_mon`

## Requirements
- R1: For each loop, an internal up state is set by a sampled reference pulse and a down state by a sampled feedback pulse. When both are set they are both cleared at the next clock edge. A pulse that is sampled in that clearing cycle is lost.
- R2: The pump controls are registered one cycle after the up and down states. With the phase-sense bit at 1, pump-up follows the up state and pump-down follows the down state. With the bit at 0 the two are swapped.
- R3: Forced high-impedance set at an edge makes pump enable, pump-up and pump-down all 0 from the next cycle. Comparison and lock measurement continue underneath.
- R4: Power-down set at an edge clears the up and down states, the width count, the good count and lock. It also drives the pump controls and the enable to 0 from the next cycle. Reset gives the same state on all outputs.
- R5: The drive-strength flag is a registered copy of the current-select input (1 = high-current mode, 0 = low-current mode).
- R6: A comparison's width is the number of cycles in which exactly one of up and down is set, saturating at 2^WIDTH_W-1. Lock is declared at the end of the LOCK_N-th consecutive comparison (default 8) whose width is strictly less than the threshold input.
- R7: A comparison whose width equals or exceeds the threshold clears lock at once and restarts the consecutive count from zero.
- R8: The per-loop lock signal is high while the loop is locked and neither up nor down is set. A locked loop therefore shows narrow low excursions during its comparisons. The signal is low when the loop is not locked.
- R9: With freq_out = 00, the monitor pin shows the following for each lock_sel value: 00 gives constant 0, 01 gives loop-0 lock, 10 gives loop-1 lock, and 11 gives the AND of both lock signals. The pin is registered one cycle after its sources.
- R10: With freq_out = 01 the monitor pin shows loop 0's feedback pulse if lock_sel[0] = 1, and its reference pulse otherwise. With freq_out = 10 it shows the same for loop 1 using lock_sel[1]. With freq_out = 11 it is constant 1. All of these are delayed one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_pls | input | 2 | One-cycle reference divider pulse per loop |
| fb_pls | input | 2 | One-cycle feedback divider pulse per loop |
| pol_pos | input | 2 | Phase sense per loop (1 = positive oscillator slope) |
| hi_cur | input | 2 | Current select per loop |
| force_hiz | input | 2 | Force pump to high impedance per loop |
| pwr_down | input | 2 | Power-down per loop |
| lock_sel | input | 2 | Monitor lock / divider selection bits |
| freq_out | input | 2 | Monitor divider-output selection bits |
| lock_thresh | input | 8 | Width threshold for a narrow comparison, in cycles |
| cp_up_o | output | 2 | Pump-up control per loop |
| cp_dn_o | output | 2 | Pump-down control per loop |
| cp_en_o | output | 2 | Pump enable per loop (0 = high impedance) |
| cp_hi_o | output | 2 | Drive-strength flag per loop |
| mon_o | output | 1 | Monitor pin |

## Verification
A stuck or wrongly cleared up/down state shows on the pump controls two cycles after the offending pulse, and one cycle after the state itself. An error in the width or good count hides until the end of a comparison. It then appears as a lock flip on the monitor pin one cycle after the clearing edge, so the bench drives the lock run across the boundary widths (threshold minus one and threshold) and across the eighth comparison. Routing errors in the monitor decode appear on the cycle after a selection change, and the bench walks every lock_sel and freq_out code while the loops are locked and while they are pulsing.

// File: rtl/pdm_pkg.sv
package pdm_pkg;
  localparam int unsigned LOOPS = 2;

  typedef enum logic [2:0] {
    MON_OFF  = 3'd0,
    MON_LOCK = 3'd1,
    MON_REF  = 3'd2,
    MON_FB   = 3'd3,
    MON_HIGH = 3'd4
  } mon_kind_e;
endpackage

// File: rtl/pdm_pfd_core.sv
module pdm_pfd_core (
  input  logic clk,
  input  logic rst,
  input  logic ref_pls,
  input  logic fb_pls,
  input  logic pol_pos,
  input  logic hi_cur,
  input  logic force_hiz,
  input  logic pwr_down,
  output logic up_q,
  output logic dn_q,
  output logic cp_up_o,
  output logic cp_dn_o,
  output logic cp_en_o,
  output logic cp_hi_o
);
  logic both_set;
  logic drive;

  assign both_set = up_q & dn_q;
  assign drive    = ~force_hiz & ~pwr_down;

  // three-state detector core
  always_ff @(posedge clk) begin
    if (rst || pwr_down) begin
      up_q <= 1'b0;
      dn_q <= 1'b0;
    end else if (both_set) begin
      up_q <= 1'b0;
      dn_q <= 1'b0;
    end else begin
      up_q <= up_q | ref_pls;
      dn_q <= dn_q | fb_pls;
    end
  end

  // registered pump controls with phase-sense swap
  always_ff @(posedge clk) begin
    if (rst) begin
      cp_up_o <= 1'b0;
      cp_dn_o <= 1'b0;
      cp_en_o <= 1'b0;
      cp_hi_o <= 1'b0;
    end else begin
      cp_up_o <= drive & (pol_pos ? up_q : dn_q);
      cp_dn_o <= drive & (pol_pos ? dn_q : up_q);
      cp_en_o <= drive;
      cp_hi_o <= hi_cur;
    end
  end

  p_clear_both_r1: assert property (@(posedge clk) disable iff (rst)
    (up_q && dn_q) |=> (!up_q && !dn_q));

  p_hiz_quiet_r3: assert property (@(posedge clk) disable iff (rst)
    force_hiz |=> (!cp_en_o && !cp_up_o && !cp_dn_o));

  p_pd_clear_r4: assert property (@(posedge clk) disable iff (rst)
    pwr_down |=> (!up_q && !dn_q && !cp_en_o && !cp_up_o && !cp_dn_o));
endmodule

// File: rtl/pdm_lock_det.sv
module pdm_lock_det #(
  parameter int unsigned WIDTH_W = 8,
  parameter int unsigned LOCK_N  = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               pwr_down,
  input  logic               up_q,
  input  logic               dn_q,
  input  logic [WIDTH_W-1:0] lock_thresh,
  output logic               lock_sig
);
  localparam int unsigned GCW = (LOCK_N > 1) ? $clog2(LOCK_N) : 1;
  localparam logic [WIDTH_W-1:0] WMAX = {WIDTH_W{1'b1}};
  localparam logic [GCW-1:0] GFULL = GCW'(LOCK_N - 1);

  logic [WIDTH_W-1:0] width_cnt;
  logic [GCW-1:0]     good_cnt;
  logic               locked;
  logic               cmp_end;
  logic               narrow;

  assign cmp_end = up_q & dn_q;
  assign narrow  = width_cnt < lock_thresh;

  always_ff @(posedge clk) begin
    if (rst || pwr_down) begin
      width_cnt <= '0;
    end else if (cmp_end) begin
      width_cnt <= '0;
    end else if ((up_q ^ dn_q) && (width_cnt != WMAX)) begin
      width_cnt <= width_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || pwr_down) begin
      good_cnt <= '0;
      locked   <= 1'b0;
    end else if (cmp_end) begin
      if (!narrow) begin
        good_cnt <= '0;
        locked   <= 1'b0;
      end else if (good_cnt == GFULL) begin
        locked   <= 1'b1;
      end else begin
        good_cnt <= good_cnt + 1'b1;
      end
    end
  end

  assign lock_sig = locked & ~(up_q | dn_q);

  p_wide_unlocks_r7: assert property (@(posedge clk) disable iff (rst)
    (cmp_end && !narrow) |=> !locked);

  p_pd_unlocks_r4: assert property (@(posedge clk) disable iff (rst)
    pwr_down |=> (!locked && width_cnt == '0));

  p_lock_needs_end_r6: assert property (@(posedge clk) disable iff (rst)
    (!locked && !cmp_end) |=> !locked);
endmodule

// File: rtl/pdm_mon_mux.sv
module pdm_mon_mux
  import pdm_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [LOOPS-1:0] lock_sig,
  input  logic [LOOPS-1:0] ref_pls,
  input  logic [LOOPS-1:0] fb_pls,
  input  logic [1:0]       lock_sel,
  input  logic [1:0]       freq_out,
  output logic             mon_o
);
  mon_kind_e  kind;
  logic       loop_idx;
  logic       lock_pick;
  logic       mon_nxt;

  always_comb begin
    kind     = MON_OFF;
    loop_idx = 1'b0;
    unique case (freq_out)
      2'b00: kind = (lock_sel == 2'b00) ? MON_OFF : MON_LOCK;
      2'b01: begin
        loop_idx = 1'b0;
        kind     = lock_sel[0] ? MON_FB : MON_REF;
      end
      2'b10: begin
        loop_idx = 1'b1;
        kind     = lock_sel[1] ? MON_FB : MON_REF;
      end
      default: kind = MON_HIGH;
    endcase
  end

  always_comb begin
    unique case (lock_sel)
      2'b01:   lock_pick = lock_sig[0];
      2'b10:   lock_pick = lock_sig[1];
      2'b11:   lock_pick = &lock_sig;
      default: lock_pick = 1'b0;
    endcase
  end

  always_comb begin
    unique case (kind)
      MON_LOCK: mon_nxt = lock_pick;
      MON_REF:  mon_nxt = ref_pls[loop_idx];
      MON_FB:   mon_nxt = fb_pls[loop_idx];
      MON_HIGH: mon_nxt = 1'b1;
      default:  mon_nxt = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) mon_o <= 1'b0;
    else     mon_o <= mon_nxt;
  end

  p_mon_off_r9: assert property (@(posedge clk) disable iff (rst)
    (lock_sel == 2'b00 && freq_out == 2'b00) |=> !mon_o);

  p_mon_high_r10: assert property (@(posedge clk) disable iff (rst)
    (freq_out == 2'b11) |=> mon_o);
endmodule

// File: rtl/pfd_lock_mon.sv
module pfd_lock_mon #(
  parameter int unsigned WIDTH_W = 8,
  parameter int unsigned LOCK_N  = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [1:0]         ref_pls,
  input  logic [1:0]         fb_pls,
  input  logic [1:0]         pol_pos,
  input  logic [1:0]         hi_cur,
  input  logic [1:0]         force_hiz,
  input  logic [1:0]         pwr_down,
  input  logic [1:0]         lock_sel,
  input  logic [1:0]         freq_out,
  input  logic [WIDTH_W-1:0] lock_thresh,
  output logic [1:0]         cp_up_o,
  output logic [1:0]         cp_dn_o,
  output logic [1:0]         cp_en_o,
  output logic [1:0]         cp_hi_o,
  output logic               mon_o
);
  import pdm_pkg::*;

  logic [LOOPS-1:0] up_q;
  logic [LOOPS-1:0] dn_q;
  logic [LOOPS-1:0] lock_sig;

  for (genvar g = 0; g < LOOPS; g++) begin : g_loop
    pdm_pfd_core u_pfd (
      .clk       (clk),
      .rst       (rst),
      .ref_pls   (ref_pls[g]),
      .fb_pls    (fb_pls[g]),
      .pol_pos   (pol_pos[g]),
      .hi_cur    (hi_cur[g]),
      .force_hiz (force_hiz[g]),
      .pwr_down  (pwr_down[g]),
      .up_q      (up_q[g]),
      .dn_q      (dn_q[g]),
      .cp_up_o   (cp_up_o[g]),
      .cp_dn_o   (cp_dn_o[g]),
      .cp_en_o   (cp_en_o[g]),
      .cp_hi_o   (cp_hi_o[g])
    );

    pdm_lock_det #(
      .WIDTH_W (WIDTH_W),
      .LOCK_N  (LOCK_N)
    ) u_lock (
      .clk         (clk),
      .rst         (rst),
      .pwr_down    (pwr_down[g]),
      .up_q        (up_q[g]),
      .dn_q        (dn_q[g]),
      .lock_thresh (lock_thresh),
      .lock_sig    (lock_sig[g])
    );
  end

  pdm_mon_mux u_mon (
    .clk      (clk),
    .rst      (rst),
    .lock_sig (lock_sig),
    .ref_pls  (ref_pls),
    .fb_pls   (fb_pls),
    .lock_sel (lock_sel),
    .freq_out (freq_out),
    .mon_o    (mon_o)
  );
endmodule

// File: tb/test_pfd_lock_mon.sv
module test_pfd_lock_mon;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] ref_pls = '0, fb_pls = '0, pol_pos = 2'b11, hi_cur = '0;
  logic [1:0] force_hiz = '0, pwr_down = '0, lock_sel = 2'b01, freq_out = '0;
  logic [7:0] lock_thresh = 8'd4;
  logic [1:0] cp_up_o, cp_dn_o, cp_en_o, cp_hi_o;
  logic       mon_o;

  int compared = 0;
  int mismatched = 0;
  bit done = 0;
  string req = "R4";

  always #4 clk = ~clk;

  pfd_lock_mon i_pfd_lock_mon (
    .clk(clk), .rst(rst), .ref_pls(ref_pls), .fb_pls(fb_pls),
    .pol_pos(pol_pos), .hi_cur(hi_cur), .force_hiz(force_hiz),
    .pwr_down(pwr_down), .lock_sel(lock_sel), .freq_out(freq_out),
    .lock_thresh(lock_thresh), .cp_up_o(cp_up_o), .cp_dn_o(cp_dn_o),
    .cp_en_o(cp_en_o), .cp_hi_o(cp_hi_o), .mon_o(mon_o)
  );

  // behavioural reference model
  int m_up[2], m_dn[2], m_w[2], m_g[2], m_lk[2];
  logic [1:0] e_up = '0, e_dn = '0, e_en = '0, e_hi = '0;
  logic e_mon = 1'b0;

  function automatic bit lock_of(int l);
    return (m_lk[l] != 0) && (m_up[l] == 0) && (m_dn[l] == 0);
  endfunction

  always @(posedge clk) begin
    bit lk0, lk1, mnext;
    if (rst) begin
      for (int l = 0; l < 2; l++) begin
        m_up[l] = 0; m_dn[l] = 0; m_w[l] = 0; m_g[l] = 0; m_lk[l] = 0;
      end
      e_up = '0; e_dn = '0; e_en = '0; e_hi = '0; e_mon = 1'b0;
    end else begin
      lk0 = lock_of(0);
      lk1 = lock_of(1);
      if (freq_out == 2'b00) begin
        if (lock_sel == 2'b01) mnext = lk0;
        else if (lock_sel == 2'b10) mnext = lk1;
        else if (lock_sel == 2'b11) mnext = lk0 && lk1;
        else mnext = 1'b0;
      end else if (freq_out == 2'b01) mnext = lock_sel[0] ? fb_pls[0] : ref_pls[0];
      else if (freq_out == 2'b10) mnext = lock_sel[1] ? fb_pls[1] : ref_pls[1];
      else mnext = 1'b1;
      e_mon = mnext;
      for (int l = 0; l < 2; l++) begin
        bit act;
        act = !force_hiz[l] && !pwr_down[l];
        e_en[l] = act;
        e_hi[l] = hi_cur[l];
        e_up[l] = act && (pol_pos[l] ? (m_up[l] != 0) : (m_dn[l] != 0));
        e_dn[l] = act && (pol_pos[l] ? (m_dn[l] != 0) : (m_up[l] != 0));
        if (pwr_down[l]) begin
          m_up[l] = 0; m_dn[l] = 0; m_w[l] = 0; m_g[l] = 0; m_lk[l] = 0;
        end else if (m_up[l] != 0 && m_dn[l] != 0) begin
          if (m_w[l] < lock_thresh) begin
            m_g[l] = m_g[l] + 1;
            if (m_g[l] >= 8) begin m_lk[l] = 1; m_g[l] = 8; end
          end else begin
            m_g[l] = 0; m_lk[l] = 0;
          end
          m_w[l] = 0; m_up[l] = 0; m_dn[l] = 0;
        end else begin
          if ((m_up[l] != 0) != (m_dn[l] != 0) && m_w[l] < 255) m_w[l] = m_w[l] + 1;
          if (ref_pls[l]) m_up[l] = 1;
          if (fb_pls[l]) m_dn[l] = 1;
        end
      end
    end
  end

  task automatic chk(string what, logic [1:0] act, logic [1:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s actual=%b expected=%b at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!done) begin
      chk("cp_up", cp_up_o, e_up);
      chk("cp_dn", cp_dn_o, e_dn);
      chk("cp_en", cp_en_o, e_en);
      chk("cp_hi", cp_hi_o, e_hi);
      chk("mon", {1'b0, mon_o}, {1'b0, e_mon});
    end
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  // one comparison on loop l: second pulse lands gap cycles after the first
  task automatic pair(int l, int gap, bit ref_first);
    if (gap == 0) begin
      ref_pls[l] = 1'b1; fb_pls[l] = 1'b1;
      @(negedge clk);
      ref_pls[l] = 1'b0; fb_pls[l] = 1'b0;
    end else begin
      if (ref_first) ref_pls[l] = 1'b1; else fb_pls[l] = 1'b1;
      @(negedge clk);
      ref_pls[l] = 1'b0; fb_pls[l] = 1'b0;
      idle(gap - 1);
      if (ref_first) fb_pls[l] = 1'b1; else ref_pls[l] = 1'b1;
      @(negedge clk);
      ref_pls[l] = 1'b0; fb_pls[l] = 1'b0;
    end
    idle(3);
  endtask

  initial begin
    req = "R4";
    idle(3);
    rst = 1'b0;
    idle(2);
    req = "R1";
    pair(0, 3, 1); pair(0, 0, 1); pair(0, 2, 0);
    // a pulse sampled in the clearing cycle is lost
    ref_pls[0] = 1'b1; fb_pls[0] = 1'b1; @(negedge clk);
    fb_pls[0] = 1'b0; @(negedge clk); ref_pls[0] = 1'b0; idle(4);
    req = "R2";
    pol_pos[0] = 1'b0; pair(0, 3, 1); pair(0, 2, 0);
    pol_pos[1] = 1'b0; pair(1, 2, 1); pol_pos = 2'b11;
    req = "R5";
    hi_cur = 2'b01; idle(2); hi_cur = 2'b10; idle(2); hi_cur = 2'b00; idle(1);
    req = "R6";
    for (int i = 0; i < 8; i++) pair(0, 3, 1);
    idle(2);
    req = "R8";
    pair(0, 2, 1); pair(0, 1, 0);
    req = "R7";
    pair(0, 4, 1);
    for (int i = 0; i < 7; i++) pair(0, 1, 1);
    idle(2);
    pair(0, 1, 1);
    req = "R3";
    force_hiz[0] = 1'b1;
    pair(0, 2, 1); pair(0, 6, 0); pair(0, 1, 1);
    force_hiz[0] = 1'b0; idle(2);
    req = "R4";
    for (int i = 0; i < 8; i++) pair(0, 1, 1);
    pwr_down[0] = 1'b1; pair(0, 1, 1); pair(0, 3, 0);
    pwr_down[0] = 1'b0; idle(2);
    pair(0, 1, 1);
    req = "R9";
    lock_sel = 2'b11;
    for (int i = 0; i < 8; i++) pair(1, 2, 1);
    lock_sel = 2'b10; idle(2);
    lock_sel = 2'b11;
    for (int i = 0; i < 8; i++) pair(0, 2, 0);
    pair(1, 1, 1);
    lock_sel = 2'b01; idle(2);
    lock_sel = 2'b00; pair(0, 1, 1);
    req = "R10";
    freq_out = 2'b01; lock_sel = 2'b00; pair(0, 3, 1);
    lock_sel = 2'b01; pair(0, 3, 1);
    freq_out = 2'b10; lock_sel = 2'b00; pair(1, 2, 0);
    lock_sel = 2'b10; pair(1, 2, 1);
    freq_out = 2'b11; idle(3);
    freq_out = 2'b00; lock_sel = 2'b00; idle(2);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      compared++;
      mismatched++;
      $display("FAIL watchdog expired during %s", req);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule